// File: doc/BRIEF.md
# Shared-Memory DRAM Slot Sequencer

This block produces every timing strobe for a small computer in which an 8-bit CPU running at 2 MHz and a video display controller share one DRAM array. A 16 MHz master timebase is acted on at both of its edges. The block models this as one fast clock plus a half-cycle step enable (`step_en`, a 32 MHz tick), which drives a 16-position one-hot ring. A full revolution of the ring is one CPU cycle. The first eight positions form the video half and the last eight form the CPU half.

From the ring position the block registers the following outputs:
- the CPU clock. Its level also steers the DRAM address multiplexer: low selects the video address and high selects the CPU address.
- a 1 MHz clock for the display controller.
- the row strobe, the row/column multiplexer select and the column strobe, repeated in each half.
- a CPU reset output.

When the CPU addresses the display controller, whose bus cycle is limited to 1 MHz, the CPU cycle is stretched so that its high phase falls inside a high phase of the display-controller clock.

The external active-low reset is synchronised. On release, a single-step start pulse puts the ring back at position 0, so the CPU clock and the display-controller clock always come back in a known phase. The ring keeps turning while reset is held, so the CPU receives clocks throughout reset. The CPU reset output is held for a programmable number of CPU cycles after the restart.

Top module: `dram_slot_sequencer`

## Requirements
- R1: On a clock edge where `step_en` is low, no output changes. On each edge where `step_en` is high, the sequence advances by one position.
- R2: A normal CPU cycle is 16 steps long. `cpu_clk` is low for positions 0 to 7 (video address to DRAM) and high for positions 8 to 15 (CPU address to DRAM).
- R3: `vdc_clk` toggles at every return to position 0, giving 16 steps high and 16 steps low. When `cpu_clk` falls at a revolution boundary, `vdc_clk` changes on the same step.
- R4: Position p is the position within an 8-step half. In each half, `ras_n` is low for p = 1 to 6, `mux_col` is high for p = 2 to 6, and `cas_n` is low for p = 3 to 6. So the row strobe falls one step before the select moves to the column address, and the column strobe falls one step after it.
- R5: `crtc_sel` is sampled only on the step into position 8. If it is high there while `vdc_clk` is low, `cpu_clk` stays low until position 8 of the next revolution, giving 24 steps low and then 8 steps high while `vdc_clk` is high. If `vdc_clk` is already high, the cycle is normal. `crtc_sel` has no effect at any other position.
- R6: `rst_n` passes through a two-flop synchroniser and one edge-detect flop. On the first `step_en` edge after the third rising clock edge following release, the ring restarts at position 0 with `cpu_clk` = 0 and `vdc_clk` = 0.
- R7: While `rst_n` is low, the ring keeps stepping and `cpu_clk` keeps toggling. From any power-up contents, the ring holds exactly one hot position after its first step.
- R8: `cpu_rst_n` goes low at once when `rst_n` falls. It stays low until the restart, then rises on the step that begins revolution `RST_HOLD_REVS`, counting the restart revolution as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock carrying the half-cycle step enable |
| rst_n | input | 1 | Asynchronous active-low system reset |
| step_en | input | 1 | Half-cycle tick; the ring advances one position per tick |
| crtc_sel | input | 1 | CPU cycle addresses the display controller |
| cpu_clk | output | 1 | CPU clock; high selects the CPU address for DRAM |
| vdc_clk | output | 1 | 1 MHz display-controller clock |
| ras_n | output | 1 | Row address strobe, active low |
| mux_col | output | 1 | Address multiplexer select: 0 row, 1 column |
| cas_n | output | 1 | Column address strobe, active low |
| cpu_rst_n | output | 1 | CPU reset, active low, held after restart |

## Verification
The bench releases reset at several different ring phases and checks that position 0 appears on the same step each time. A restart that depended on where the ring happened to be would put `cpu_clk` and `vdc_clk` out of phase. It stretches a cycle that addresses the display controller from the video-clock-low revolution and checks the 24/8 shape. A wrong stretch would raise the CPU clock while the controller clock is low, or shift every later cycle. It also drives `crtc_sel` at positions other than 8 and checks that nothing changes. Finally, it pauses `step_en` and checks that the outputs hold, and checks the exact revolution in which the CPU reset is released, where an off-by-one counter would show up.

// File: rtl/seq_pkg.sv
package seq_pkg;

  // Positions inside one 8-step half (video or CPU) where the DRAM strobes act.
  localparam int RowStrobePos = 1;
  localparam int ColSelectPos = 2;
  localparam int ColStrobePos = 3;
  // Positions left idle at the top of each half so the DRAM can precharge.
  localparam int IdleTail     = 1;

  typedef struct packed {
    logic ras_n;
    logic mux_col;
    logic cas_n;
  } dram_strobe_t;

  // Strobe levels at position pos of a half that is half_len steps long.
  function automatic dram_strobe_t strobe_at(int pos, int half_len);
    dram_strobe_t s;
    int last;
    last      = half_len - 1 - IdleTail;
    s.ras_n   = !((pos >= RowStrobePos) && (pos <= last));
    s.mux_col =   (pos >= ColSelectPos) && (pos <= last);
    s.cas_n   = !((pos >= ColStrobePos) && (pos <= last));
    return s;
  endfunction

endpackage

// File: rtl/seq_reset_sync.sv
module seq_reset_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step_en,
  output logic sys_rst,
  output logic load
);

  // One extra stage behind the synchroniser serves as the edge detector.
  logic [SYNC_STAGES:0] sync_q;
  logic [SYNC_STAGES:0] sync_d;
  logic                 arm_q;
  logic                 arm_d;
  logic                 release_edge;

  always_comb begin
    sync_d       = {sync_q[SYNC_STAGES-1:0], 1'b1};
    release_edge = sync_q[SYNC_STAGES-1] & ~sync_q[SYNC_STAGES];
    // The start request waits for the next step, then lives exactly one step.
    arm_d        = release_edge | (arm_q & ~step_en);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      arm_q  <= 1'b0;
    end else begin
      sync_q <= sync_d;
      arm_q  <= arm_d;
    end
  end

  assign sys_rst = ~sync_q[SYNC_STAGES-1];
  assign load    = arm_q & step_en;

  AST_START_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_q && step_en) |=> !arm_q); // R6

endmodule

// File: rtl/seq_slot_ring.sv
module seq_slot_ring #(
  parameter int SLOTS = 16,
  parameter int IW    = $clog2(SLOTS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step_en,
  input  logic          load,
  output logic [IW-1:0] cur_idx,
  output logic [IW-1:0] nxt_idx
);

  // No reset on purpose: the ring must keep turning while reset is held.
  logic [SLOTS-1:0] ring_q;
  logic [SLOTS-1:0] ring_d;
  logic             legal;

  always_comb begin
    legal = (ring_q != '0) && ((ring_q & (ring_q - SLOTS'(1))) == '0);
    if (load || !legal) begin
      ring_d = SLOTS'(1);
    end else begin
      ring_d = {ring_q[SLOTS-2:0], ring_q[SLOTS-1]};
    end
  end

  always_comb begin
    cur_idx = '0;
    nxt_idx = '0;
    for (int i = 0; i < SLOTS; i++) begin
      if (ring_q[i]) cur_idx = IW'(i);
      if (ring_d[i]) nxt_idx = IW'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (step_en) begin
      ring_q <= ring_d;
    end
  end

  AST_RING_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $past(step_en) |-> $onehot(ring_q)); // R7

endmodule

// File: rtl/seq_phase_gen.sv
module seq_phase_gen
  import seq_pkg::*;
#(
  parameter int SLOTS = 16,
  parameter int IW    = $clog2(SLOTS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step_en,
  input  logic          load,
  input  logic          crtc_sel,
  input  logic [IW-1:0] nxt_idx,
  output logic          cpu_clk,
  output logic          vdc_clk,
  output logic          ras_n,
  output logic          mux_col,
  output logic          cas_n
);

  localparam int HALF            = SLOTS / 2;
  localparam int HW              = IW - 1;
  localparam logic [IW-1:0] CPU_START = IW'(HALF);

  logic         cpu_q, cpu_d;
  logic         vdc_q, vdc_d;
  logic         stretch_q, stretch_d;
  dram_strobe_t strobe_q, strobe_d;

  always_comb begin
    strobe_d  = strobe_at(int'(nxt_idx[HW-1:0]), HALF);
    cpu_d     = cpu_q;
    vdc_d     = vdc_q;
    stretch_d = stretch_q;
    if (load) begin
      cpu_d     = 1'b0;
      vdc_d     = 1'b0;
      stretch_d = 1'b0;
    end else if (nxt_idx == '0) begin
      cpu_d = 1'b0;
      vdc_d = ~vdc_q;
    end else if (nxt_idx == CPU_START) begin
      if (stretch_q) begin
        cpu_d     = 1'b1;
        stretch_d = 1'b0;
      end else if (crtc_sel && !vdc_q) begin
        cpu_d     = 1'b0;
        stretch_d = 1'b1;
      end else begin
        cpu_d = 1'b1;
      end
    end
  end

  // Outputs are loaded only on steps; loaded from load, not from rst_n.
  always_ff @(posedge clk) begin
    if (step_en) begin
      cpu_q     <= cpu_d;
      vdc_q     <= vdc_d;
      stretch_q <= stretch_d;
      strobe_q  <= strobe_d;
    end
  end

  assign cpu_clk = cpu_q;
  assign vdc_clk = vdc_q;
  assign ras_n   = strobe_q.ras_n;
  assign mux_col = strobe_q.mux_col;
  assign cas_n   = strobe_q.cas_n;

  AST_ROW_BEFORE_COL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strobe_q.mux_col) |-> (!strobe_q.ras_n && $past(!strobe_q.ras_n))); // R4

  AST_COL_BEFORE_CAS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(strobe_q.cas_n) |-> (strobe_q.mux_col && $past(strobe_q.mux_col))); // R4

  AST_CPU_FALL_TOGGLES_VDC: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cpu_q) && !$past(load)) |-> (vdc_q != $past(vdc_q))); // R3

  AST_STRETCH_IN_VDC_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cpu_q) && $past(stretch_q)) |-> vdc_q); // R5

  AST_HOLD_WITHOUT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(step_en) |-> $stable({cpu_q, vdc_q, strobe_q})); // R1

endmodule

// File: rtl/seq_cpu_reset.sv
module seq_cpu_reset #(
  parameter int SLOTS         = 16,
  parameter int RST_HOLD_REVS = 4,
  parameter int IW            = $clog2(SLOTS),
  parameter int CW            = $clog2(RST_HOLD_REVS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sys_rst,
  input  logic          step_en,
  input  logic          load,
  input  logic [IW-1:0] nxt_idx,
  input  logic [IW-1:0] cur_idx,
  output logic          cpu_rst_n
);

  localparam logic [CW-1:0] LAST_REV = CW'(RST_HOLD_REVS - 1);

  logic          run_q, run_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          rel_q, rel_d;
  logic          wrap;

  always_comb begin
    wrap  = (nxt_idx == '0);
    run_d = run_q;
    cnt_d = cnt_q;
    rel_d = rel_q;
    if (sys_rst) begin
      run_d = 1'b0;
      cnt_d = '0;
      rel_d = 1'b0;
    end else if (step_en) begin
      if (load) begin
        run_d = 1'b1;
        cnt_d = '0;
        rel_d = 1'b0;
      end else if (run_q && wrap && !rel_q) begin
        cnt_d = cnt_q + CW'(1);
        rel_d = (cnt_q == LAST_REV);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
      rel_q <= 1'b0;
    end else begin
      run_q <= run_d;
      cnt_q <= cnt_d;
      rel_q <= rel_d;
    end
  end

  assign cpu_rst_n = rel_q;

  AST_RELEASE_AT_SLOT0: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rel_q) |-> (cur_idx == '0)); // R8

endmodule

// File: rtl/dram_slot_sequencer.sv
module dram_slot_sequencer #(
  parameter int SLOTS         = 16,
  parameter int RST_HOLD_REVS = 4,
  parameter int SYNC_STAGES   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step_en,
  input  logic crtc_sel,
  output logic cpu_clk,
  output logic vdc_clk,
  output logic ras_n,
  output logic mux_col,
  output logic cas_n,
  output logic cpu_rst_n
);

  localparam int IW = $clog2(SLOTS);

  logic          sys_rst;
  logic          load;
  logic [IW-1:0] cur_idx;
  logic [IW-1:0] nxt_idx;

  seq_reset_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .step_en (step_en),
    .sys_rst (sys_rst),
    .load    (load)
  );

  seq_slot_ring #(.SLOTS(SLOTS), .IW(IW)) u_ring (
    .clk     (clk),
    .rst_n   (rst_n),
    .step_en (step_en),
    .load    (load),
    .cur_idx (cur_idx),
    .nxt_idx (nxt_idx)
  );

  seq_phase_gen #(.SLOTS(SLOTS), .IW(IW)) u_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .step_en  (step_en),
    .load     (load),
    .crtc_sel (crtc_sel),
    .nxt_idx  (nxt_idx),
    .cpu_clk  (cpu_clk),
    .vdc_clk  (vdc_clk),
    .ras_n    (ras_n),
    .mux_col  (mux_col),
    .cas_n    (cas_n)
  );

  seq_cpu_reset #(.SLOTS(SLOTS), .RST_HOLD_REVS(RST_HOLD_REVS), .IW(IW)) u_cpurst (
    .clk       (clk),
    .rst_n     (rst_n),
    .sys_rst   (sys_rst),
    .step_en   (step_en),
    .load      (load),
    .nxt_idx   (nxt_idx),
    .cur_idx   (cur_idx),
    .cpu_rst_n (cpu_rst_n)
  );

endmodule

// File: tb/test_dram_slot_sequencer.sv
`timescale 1ns/1ps
module test_dram_slot_sequencer;

  localparam int SLOTS = 16;
  localparam int HOLD  = 4;

  // Expected {cpu_clk, ras_n, mux_col, cas_n} per ring position (R2, R4).
  localparam logic [3:0] VEC [16] = '{
    4'b0101, 4'b0001, 4'b0011, 4'b0010, 4'b0010, 4'b0010, 4'b0010, 4'b0101,
    4'b1101, 4'b1001, 4'b1011, 4'b1010, 4'b1010, 4'b1010, 4'b1010, 4'b1101
  };

  logic clk = 1'b0;
  logic rst_n, step_en, crtc_sel;
  logic cpu_clk, vdc_clk, ras_n, mux_col, cas_n, cpu_rst_n;
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   done  = 0;

  always #2.5 clk = ~clk;

  dram_slot_sequencer #(.SLOTS(SLOTS), .RST_HOLD_REVS(HOLD)) i_dram_slot_sequencer (
    .clk(clk), .rst_n(rst_n), .step_en(step_en), .crtc_sel(crtc_sel),
    .cpu_clk(cpu_clk), .vdc_clk(vdc_clk), .ras_n(ras_n), .mux_col(mux_col),
    .cas_n(cas_n), .cpu_rst_n(cpu_rst_n)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic release_reset();
    rst_n = 1'b1;
    repeat (3) tick();
  endtask

  initial begin
    int rises;
    logic prev;
    rst_n = 1'b0; step_en = 1'b1; crtc_sel = 1'b0;

    // R7: clocks run while reset is held; R8: CPU reset stays low.
    repeat (3) tick();
    rises = 0;
    prev  = cpu_clk;
    for (int i = 0; i < 40; i++) begin
      tick();
      if (cpu_clk && !prev) rises++;
      prev = cpu_clk;
      chk("R8 held in reset", {7'd0, cpu_rst_n}, 8'd0);
    end
    chk("R7 cpu_clk rises in reset", {7'd0, rises >= 2}, 8'd1);

    // Table walk over five revolutions after restart.
    release_reset();
    for (int k = 0; k < 80; k++) begin
      tick();
      chk("R2 cpu_clk", {7'd0, cpu_clk}, {7'd0, VEC[k % 16][3]});
      chk("R4 strobes", {5'd0, ras_n, mux_col, cas_n}, {5'd0, VEC[k % 16][2:0]});
      chk("R3 vdc_clk", {7'd0, vdc_clk}, 8'((k / 16) % 2));
      chk("R8 release revolution", {7'd0, cpu_rst_n}, {7'd0, k >= 16 * HOLD});
      if (k == 0) chk("R6 restart phase", {3'd0, vdc_clk, cpu_clk, ras_n, mux_col, cas_n}, 8'b0000_0101);
    end

    // R1: pause steps, outputs hold; then one step advances one position.
    step_en = 1'b0;
    repeat (10) tick();
    chk("R1 hold", {3'd0, vdc_clk, cpu_clk, ras_n, mux_col, cas_n}, {3'd0, 1'b0, VEC[15]});
    step_en = 1'b1;
    tick();
    chk("R1 resume", {3'd0, vdc_clk, cpu_clk, ras_n, mux_col, cas_n}, {3'd0, 1'b1, VEC[0]});

    // R8: CPU reset falls asynchronously.
    rst_n = 1'b0;
    #1;
    chk("R8 async assert", {7'd0, cpu_rst_n}, 8'd0);
    repeat (7) tick();

    // R5: display access from the video-clock-low revolution is stretched 24/8.
    crtc_sel = 1'b1;
    release_reset();
    for (int k = 0; k < 48; k++) begin
      tick();
      chk("R5 stretched cpu_clk", {7'd0, cpu_clk},
          {7'd0, (k >= 24 && k < 32) || (k >= 40)});
      chk("R4 strobes in stretch", {5'd0, ras_n, mux_col, cas_n}, {5'd0, VEC[k % 16][2:0]});
      chk("R3 vdc in stretch", {7'd0, vdc_clk}, 8'((k / 16) % 2));
      crtc_sel = ((k + 1) <= 24);
    end

    // R5: select outside position 8, or with vdc_clk high, leaves the cycle normal.
    rst_n = 1'b0;
    repeat (13) tick();
    crtc_sel = 1'b0;
    release_reset();
    for (int k = 0; k < 32; k++) begin
      tick();
      chk("R5 select ignored", {7'd0, cpu_clk}, {7'd0, VEC[k % 16][3]});
      crtc_sel = (((k + 1) >= 2) && ((k + 1) <= 5)) || ((k + 1) == 24);
    end
    chk("R6 phase after late release", {7'd0, vdc_clk}, 8'd1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule